// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block is the register face that a host processor sees on a floppy disk controller. Three byte-wide registers sit on a small address bus. The first is a drive control register, which holds the four spindle motor enables, a gate for the transfer and interrupt path, an active-low controller reset and a two-bit unit select. The second is a read-only status register. The third is a data port that carries command bytes into the controller and result bytes back out.

The host must read the status register before every data-port access. Bit 7 tells it whether the port can be used now, and bit 6 tells it whether the port expects a read or a write. A simple sequencer stands in for the real command engine. It takes a fixed number of command bytes and then works for a configurable number of cycles. It then offers a fixed number of result bytes, each derived from the stored command bytes, and raises an interrupt when those results appear. Any data-port access that breaks the handshake is ignored and sets a sticky error flag.

Top module: `fdc_host_regs`

## Requirements
- R1: The drive control register (offset 1) is 0x00 after `rst`. It drives `motor_en[3:0]` from bits 7:4, with bit 4 for unit 0 and bit 7 for unit 3 (1 runs the motor). It drives `dma_gate` from bit 3, `ctl_rst_n` from bit 2 and `drive_sel` from bits 1:0. Writing 0x1C gives motor 0 on, gate on, reset released and unit 0.
- R2: The status register (offset 4) reads {ready, dir, 0, busy, 4'b0000}. Bit 7 set means the data port (offset 5) may be accessed. Bit 6 set means the host must read it, and clear means the host must write it. Bit 4 set means a command is in progress. One cycle after reset is released, the status register reads 0x80.
- R3: While bit 2 of the drive control register is 0, the sequencer is held in reset. During this time the status register reads 0x00, any command bytes already taken are discarded, and the error flag is cleared.
- R4: In the write phase the data port accepts CMD_BYTES writes. Once at least one byte is accepted, the status register reads 0x90.
- R5: After the last command byte is accepted, the ready bit stays low (status 0x10) for exactly BUSY_CYCLES cycles. The status register then reads 0xD0.
- R6: Result byte k equals command byte (k mod CMD_BYTES) XOR (k+1). After the last of RES_BYTES results has been read, the status register reads 0x80 again.
- R7: `irq` rises one cycle after results become available, but only while bit 3 of the drive control register is 1. A pending interrupt appears one cycle after that bit is set.
- R8: The pending interrupt clears when the first result byte is read, and `irq` falls one cycle later.
- R9: A data-port access that is not allowed has no effect and sets `err_sticky` (1 = error seen). This covers any access while ready is 0, a read in the write phase and a write in the read phase. An ignored read returns 0x00.
- R10: `bus_rdata` is registered and holds the read value in the cycle after the read strobe. The drive control register reads back its contents. Offsets other than 1, 4 and 5 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| motor_en | output | 4 | Spindle motor enables, bit n for unit n |
| dma_gate | output | 1 | Transfer and interrupt path enable |
| ctl_rst_n | output | 1 | Controller reset, active low |
| drive_sel | output | 2 | Selected unit |
| irq | output | 1 | Command-complete interrupt |
| err_sticky | output | 1 | Sticky handshake violation flag |

## Verification
The hardest situations to reach are a pending interrupt that is masked and a command stream cut off partway through. To reach the masked case, the bench runs a whole command with the gate bit cleared, confirms that `irq` stays low while the status register already reports results, and only then sets the gate. To reach the cut-off case, it sends one command byte, pulses the reset bit in the drive control register, and then sends a full new command. The result values show whether the stray byte was discarded.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_PORT = 3'd5;

  // control register field positions
  localparam int CTRL_MOTOR_LSB = 4;
  localparam int CTRL_GATE_BIT  = 3;
  localparam int CTRL_NRST_BIT  = 2;

  typedef enum logic [1:0] {
    PH_HOLD,
    PH_CMD,
    PH_EXEC,
    PH_RES
  } fdc_phase_e;
endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CMD_BYTES   = 3,
  parameter int RES_BYTES   = 2,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wdata,
  output fdc_phase_e        phase,
  output logic              cmd_busy,
  output logic              rd_ok,
  output logic [DATA_W-1:0] res_byte,
  output logic              irq_pend,
  output logic              err
);
  localparam int CIDX_W = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;
  localparam int RIDX_W = (RES_BYTES > 1) ? $clog2(RES_BYTES) : 1;
  localparam int TMR_W  = $clog2(BUSY_CYCLES + 1);
  localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CMD_BYTES - 1);
  localparam logic [RIDX_W-1:0] RIDX_LAST = RIDX_W'(RES_BYTES - 1);
  localparam logic [TMR_W-1:0]  TMR_LOAD  = TMR_W'(BUSY_CYCLES - 1);

  logic [DATA_W-1:0] cmd_mem [CMD_BYTES];
  logic [CIDX_W-1:0] cmd_idx;
  logic [RIDX_W-1:0] res_idx;
  logic [TMR_W-1:0]  tmr;
  logic [CIDX_W-1:0] src_idx;
  logic              wr_ok;
  logic              bad;

  assign wr_ok = wr_req && (phase == PH_CMD) && !hold;
  assign rd_ok = rd_req && (phase == PH_RES) && !hold;
  assign bad   = (wr_req && !wr_ok) || (rd_req && !rd_ok);

  // command byte store: plain write port, no reset, RAM friendly
  always_ff @(posedge clk) begin
    if (wr_ok) cmd_mem[cmd_idx] <= wdata;
  end

  always_comb src_idx = CIDX_W'(32'(res_idx) % CMD_BYTES);
  assign res_byte = cmd_mem[src_idx] ^ DATA_W'(32'(res_idx) + 1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase    <= PH_HOLD;
      cmd_idx  <= '0;
      res_idx  <= '0;
      tmr      <= '0;
      irq_pend <= 1'b0;
    end else begin
      unique case (phase)
        PH_HOLD: phase <= PH_CMD;
        PH_CMD: begin
          if (wr_ok) begin
            if (cmd_idx == CIDX_LAST) begin
              cmd_idx <= '0;
              tmr     <= TMR_LOAD;
              phase   <= PH_EXEC;
            end else begin
              cmd_idx <= cmd_idx + 1'b1;
            end
          end
        end
        PH_EXEC: begin
          if (tmr == '0) begin
            phase    <= PH_RES;
            res_idx  <= '0;
            irq_pend <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        PH_RES: begin
          if (rd_ok) begin
            if (res_idx == '0) irq_pend <= 1'b0;
            if (res_idx == RIDX_LAST) begin
              res_idx <= '0;
              phase   <= PH_CMD;
            end else begin
              res_idx <= res_idx + 1'b1;
            end
          end
        end
        default: phase <= PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) err <= 1'b0;
    else if (bad)    err <= 1'b1;
  end

  assign cmd_busy = ((phase == PH_CMD) && (cmd_idx != '0)) ||
                    (phase == PH_EXEC) || (phase == PH_RES);
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CMD_BYTES   = 3,
  parameter int RES_BYTES   = 2,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [3:0]        motor_en,
  output logic              dma_gate,
  output logic              ctl_rst_n,
  output logic [1:0]        drive_sel,
  output logic              irq,
  output logic              err_sticky
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_val;
  logic [DATA_W-1:0] res_byte;
  fdc_phase_e        phase;
  logic              cmd_busy;
  logic              rd_ok;
  logic              irq_pend;
  logic              wr_ctrl;
  logic              wr_port;
  logic              rd_port;
  logic              seq_hold;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_port  = bus_wr && (bus_addr == OFS_PORT);
  assign rd_port  = bus_rd && (bus_addr == OFS_PORT);
  assign seq_hold = !ctrl_q[CTRL_NRST_BIT];

  fdc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  fdc_cmd_seq #(
    .DATA_W      (DATA_W),
    .CMD_BYTES   (CMD_BYTES),
    .RES_BYTES   (RES_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .hold     (seq_hold),
    .wr_req   (wr_port),
    .rd_req   (rd_port),
    .wdata    (bus_wdata),
    .phase    (phase),
    .cmd_busy (cmd_busy),
    .rd_ok    (rd_ok),
    .res_byte (res_byte),
    .irq_pend (irq_pend),
    .err      (err_sticky)
  );

  always_comb begin
    stat_val    = '0;
    stat_val[7] = (phase == PH_CMD) || (phase == PH_RES);
    stat_val[6] = (phase == PH_RES);
    stat_val[4] = cmd_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata <= ctrl_q;
        OFS_STAT: bus_rdata <= stat_val;
        OFS_PORT: bus_rdata <= rd_ok ? res_byte : '0;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_pend && ctrl_q[CTRL_GATE_BIT];
  end

  assign motor_en  = ctrl_q[CTRL_MOTOR_LSB +: 4];
  assign dma_gate  = ctrl_q[CTRL_GATE_BIT];
  assign ctl_rst_n = ctrl_q[CTRL_NRST_BIT];
  assign drive_sel = ctrl_q[1:0];
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk (
  input logic clk,
  input logic rst,
  input logic ctl_rst_n,
  input logic dma_gate,
  input logic irq,
  input logic irq_pend,
  input logic err_sticky,
  input logic st_ready,
  input logic st_dir,
  input logic wr_port,
  input logic rd_port
);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(dma_gate));

  p_hold_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl_rst_n |=> !st_ready);

  p_err_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && ctl_rst_n) |=> err_sticky);

  p_bad_write_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_port && ctl_rst_n && !(st_ready && !st_dir)) |=> err_sticky);

  p_read_clears_pend_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_port && ctl_rst_n && st_ready && st_dir) |=> !irq_pend);
endmodule

bind fdc_host_regs fdc_host_regs_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_rst_n  (ctl_rst_n),
  .dma_gate   (dma_gate),
  .irq        (irq),
  .irq_pend   (irq_pend),
  .err_sticky (err_sticky),
  .st_ready   (stat_val[7]),
  .st_dir     (stat_val[6]),
  .wr_port    (wr_port),
  .rd_port    (rd_port)
);

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_N  = 3;
  localparam int RES_N  = 2;
  localparam int BUSY_N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] motor_en;
  logic       dma_gate, ctl_rst_n, irq, err_sticky;
  logic [1:0] drive_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_regs #(.CMD_BYTES(CMD_N), .RES_BYTES(RES_N), .BUSY_CYCLES(BUSY_N)) i_fdc_host_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .motor_en(motor_en),
    .dma_gate(dma_gate), .ctl_rst_n(ctl_rst_n), .drive_sel(drive_sel),
    .irq(irq), .err_sticky(err_sticky)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: read strobe seen at an edge, compare read data at the following negedge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard actual=%02h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        chk(e.req, bus_rdata, e.exp);
      end
    end
  end

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, logic [7:0] exp, string req);
    exp_t e;
    e.exp = exp; e.req = req;
    exp_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R1 motors after reset", {4'h0, motor_en}, 8'h00);
    chk("R1 gate/rst_n/sel after reset", {5'h0, dma_gate, ctl_rst_n, 1'b0}, 8'h00);
    chk("R7 irq after reset", {7'h0, irq}, 8'h00);
    chk("R9 err after reset", {7'h0, err_sticky}, 8'h00);
    bus_read(3'd4, 8'h00, "R3 status while held");
    bus_read(3'd1, 8'h00, "R10 control readback reset");

    bus_write(3'd1, 8'h1C);
    chk("R1 0x1C motors", {4'h0, motor_en}, 8'h01);
    chk("R1 0x1C gate/rst_n/sel", {4'h0, dma_gate, ctl_rst_n, drive_sel}, 8'h0C);
    idle(1);
    bus_read(3'd4, 8'h80, "R2 ready write after release");

    bus_write(3'd1, 8'hA6);
    chk("R1 0xA6 motors", {4'h0, motor_en}, 8'h0A);
    chk("R1 0xA6 gate/rst_n/sel", {4'h0, dma_gate, ctl_rst_n, drive_sel}, 8'h06);
    bus_read(3'd1, 8'hA6, "R10 control readback");
    bus_write(3'd1, 8'h1C);

    // wrong direction read in write phase
    bus_read(3'd5, 8'h00, "R9 ignored read data");
    chk("R9 err after wrong-direction read", {7'h0, err_sticky}, 8'h01);
    bus_read(3'd4, 8'h80, "R9 status unchanged");

    // hold clears error
    bus_write(3'd1, 8'h18);
    idle(1);
    chk("R3 err cleared by hold", {7'h0, err_sticky}, 8'h00);
    bus_read(3'd4, 8'h00, "R3 status held");
    bus_write(3'd1, 8'h1C);
    idle(1);

    // command A with exact busy window
    bus_write(3'd5, 8'h3C);
    bus_read(3'd4, 8'h90, "R4 busy after first byte");
    bus_write(3'd5, 8'h5A);
    bus_write(3'd5, 8'h81);
    idle(BUSY_N - 1);
    bus_read(3'd4, 8'h10, "R5 last not-ready cycle");
    bus_read(3'd4, 8'hD0, "R5 results ready");
    chk("R7 irq raised", {7'h0, irq}, 8'h01);
    bus_read(3'd5, 8'h3D, "R6 result 0");
    idle(1);
    chk("R8 irq cleared after first result", {7'h0, irq}, 8'h00);
    bus_read(3'd5, 8'h58, "R6 result 1");
    bus_read(3'd4, 8'h80, "R6 back to write phase");
    chk("R9 no error on legal traffic", {7'h0, err_sticky}, 8'h00);

    // command B with the interrupt gate closed
    bus_write(3'd1, 8'h14);
    bus_write(3'd5, 8'h11);
    bus_write(3'd5, 8'h22);
    bus_write(3'd5, 8'h33);
    idle(BUSY_N + 2);
    chk("R7 irq gated off", {7'h0, irq}, 8'h00);
    bus_read(3'd4, 8'hD0, "R5 results ready gated");
    bus_write(3'd5, 8'hFF);
    chk("R9 err after write in read phase", {7'h0, err_sticky}, 8'h01);
    bus_write(3'd1, 8'h1C);
    idle(1);
    chk("R7 irq after gate opens", {7'h0, irq}, 8'h01);
    bus_read(3'd5, 8'h10, "R6 result 0 cmd B");
    bus_read(3'd5, 8'h20, "R6 result 1 cmd B");
    bus_read(3'd4, 8'h80, "R6 idle after cmd B");

    // partial command discarded by hold
    bus_write(3'd5, 8'h77);
    bus_write(3'd1, 8'h18);
    idle(1);
    bus_write(3'd1, 8'h1C);
    idle(1);
    chk("R3 err cleared", {7'h0, err_sticky}, 8'h00);
    bus_read(3'd4, 8'h80, "R3 partial command discarded");
    bus_write(3'd5, 8'h40);
    bus_write(3'd5, 8'h50);
    bus_write(3'd5, 8'h60);
    bus_write(3'd5, 8'h99);
    chk("R9 err after write while busy", {7'h0, err_sticky}, 8'h01);
    idle(BUSY_N);
    bus_read(3'd5, 8'h41, "R3 result 0 from fresh bytes");
    bus_read(3'd5, 8'h52, "R9 result 1 unaffected by ignored write");

    // unused offset
    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, 8'h00, "R10 unused offset reads zero");
    bus_read(3'd1, 8'h1C, "R10 control untouched by unused offset");
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule